// File: doc/BRIEF.md
# Two-Level Trigger Latency Pipeline

This block delays per-crossing hit data by a programmable number of crossings and keeps the events that a first-level trigger accepts. Each bunch-crossing strobe writes the current hit word into a circular pipeline memory and moves the write pointer forward by one. When a first-level accept arrives, the block reads the word written `lat_cfg` strobes earlier. That address comes from subtracting `lat_cfg` from the write pointer, modulo the pipeline depth. The word is copied into a small event buffer together with an 8-bit event ID from a local counter.

Second-level and regional-readout requests do not arrive at a fixed latency, so they find their event by its ID. A second-level request reads the event and releases its slot. A regional request reads a copy and leaves the event in place. Slots return to the free pool strictly in the order they were filled. If a first-level accept arrives while the buffer is full, the event is dropped and counted. A request whose ID is not stored raises a one-cycle miss flag.

Requests enter on a valid/ready port and results leave on a valid/ready port. The output is one register stage. While a result waits with `out_ready` low, `req_ready` stays low, so back-pressure reaches the request source directly. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A result moves on an edge where `out_valid` and `out_ready` are both high.

Top module: `trig_latency_pipe`

## Requirements
- R1: Every cycle with `bc_strobe` high writes `hit_word` into the pipeline at the write pointer, and the write pointer then advances by one modulo `PIPE_DEPTH`; cycles without the strobe write nothing.
- R2: A first-level accept stores the hit word written `lat_cfg` strobes before the accept cycle (1 <= `lat_cfg` < `PIPE_DEPTH`). This holds whether or not a strobe occurs in that same cycle, and a same-cycle strobe does not affect the stored word.
- R3: Event IDs are handed out from 0 after reset and increase by one for each stored event, wrapping from 255 to 0. Each result carries the ID of the event it belongs to on `out_id`.
- R4: An accepted request with `req_regional`=0 whose ID is stored produces one result with that event's data on the cycle after acceptance, with `out_regional`=0. The event is consumed, so a later request for the same ID misses.
- R5: An accepted request with `req_regional`=1 whose ID is stored produces one result with `out_regional`=1 and leaves the event available for later requests.
- R6: An accepted request whose ID is not stored raises `req_miss` for exactly the following cycle and produces no result.
- R7: A first-level accept that arrives while all `EVB_SLOTS` slots are held stores nothing, uses up no event ID, and adds one to `ovf_count`.
- R8: Slots are released oldest first. A consumed event frees its slot only after every older event has been consumed, so the buffer stays full until the oldest event is consumed.
- R9: `req_ready` is high exactly when `out_valid` is low or `out_ready` is high. A result held with `out_ready` low keeps `out_valid`, `out_data`, `out_id` and `out_regional` unchanged.
- R10: After reset, `out_valid`=0, `req_miss`=0, `ovf_count`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_strobe | input | 1 | Bunch-crossing strobe, writes one pipeline word |
| hit_word | input | DATA_W | Hit data for the current crossing |
| lat_cfg | input | $clog2(PIPE_DEPTH) | First-level latency in strobes |
| l1_accept | input | 1 | First-level trigger |
| req_valid | input | 1 | Readout request valid |
| req_ready | output | 1 | Request can be taken |
| req_id | input | ID_W | Event ID being requested |
| req_regional | input | 1 | 1: regional copy read, 0: second-level read that consumes |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | DATA_W | Event hit data |
| out_id | output | ID_W | Event ID of the result |
| out_regional | output | 1 | Result came from a regional request |
| req_miss | output | 1 | One-cycle flag: requested ID not stored |
| ovf_count | output | CNT_W | Count of first-level accepts dropped on a full buffer |

## Verification
Each hit word is a distinct function of its strobe index. A wrong latency subtraction, an off-by-one on same-cycle strobes, or a missed write therefore shows up as a data mismatch. The latency is swept across small, mid and maximum values, and accepts are issued both with and without a strobe in the same cycle. Requests exercise hits, regional copies that must leave the event in place, consumed IDs and never-issued IDs; this separates the consume path from the copy path and the miss path. A fill-past-full sequence with the oldest event read last shows whether slots are released in order. A run of more than 256 events shows whether the ID counter wraps and whether dropped events use up IDs. A stretch with `out_ready` low checks that the result holds steady and that requests are refused.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  typedef enum logic {
    REQ_SECOND   = 1'b0,
    REQ_REGIONAL = 1'b1
  } req_kind_e;
endpackage

// File: rtl/tlp_pipeline.sv
module tlp_pipeline #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_strobe,
  input  logic [DATA_W-1:0] hit_word,
  input  logic [AW-1:0]     lat,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wa;
  logic [AW-1:0]     ra;

  // modulo-DEPTH subtraction: DEPTH is a power of two
  assign ra      = wa - lat;
  assign rd_word = mem[ra];

  always_ff @(posedge clk) begin
    if (bc_strobe) mem[wa] <= hit_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         wa <= '0;
    else if (bc_strobe) wa <= wa + 1'b1;
  end
endmodule

// File: rtl/tlp_evbuf.sv
module tlp_evbuf #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 8,
  parameter int SLOTS  = 4,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ID_W-1:0]   wr_id,
  output logic              full,
  input  logic              lk_en,
  input  logic              lk_consume,
  input  logic [ID_W-1:0]   lk_id,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [ID_W-1:0]   slot_id   [SLOTS];
  logic [SLOTS-1:0]  occ, done, match;
  logic [SW-1:0]     wptr, rptr, hit_idx;
  logic [SW:0]       count;
  logic              do_wr, retire, do_cons;

  assign full    = (count == (SW+1)'(SLOTS));
  assign do_wr   = wr_en && !full;
  assign retire  = occ[rptr] && done[rptr];
  assign do_cons = lk_en && lk_consume && lk_hit;

  for (genvar i = 0; i < SLOTS; i++) begin : g_match
    assign match[i] = occ[i] && !done[i] && (slot_id[i] == lk_id);
  end

  always_comb begin
    lk_hit  = 1'b0;
    hit_idx = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit  = 1'b1;
        hit_idx = SW'(i);
      end
    end
  end
  assign lk_data = slot_data[hit_idx];

  always_ff @(posedge clk) begin
    if (do_wr) begin
      slot_data[wptr] <= wr_data;
      slot_id[wptr]   <= wr_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ  <= '0;
      done <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (retire && rptr == SW'(i)) begin
          occ[i]  <= 1'b0;
          done[i] <= 1'b0;
        end
        if (do_wr && wptr == SW'(i)) begin
          occ[i]  <= 1'b1;
          done[i] <= 1'b0;
        end
        if (do_cons && hit_idx == SW'(i)) done[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr)  wptr <= (wptr == SW'(SLOTS-1)) ? '0 : wptr + 1'b1;
      if (retire) rptr <= (rptr == SW'(SLOTS-1)) ? '0 : rptr + 1'b1;
      count <= count + (SW+1)'(do_wr) - (SW+1)'(retire);
    end
  end
endmodule

// File: rtl/trig_latency_pipe.sv
module trig_latency_pipe
  import tlp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PIPE_DEPTH = 64,
  parameter int EVB_SLOTS  = 4,
  parameter int ID_W       = 8,
  parameter int CNT_W      = 16,
  localparam int PAW       = $clog2(PIPE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_strobe,
  input  logic [DATA_W-1:0] hit_word,
  input  logic [PAW-1:0]    lat_cfg,
  input  logic              l1_accept,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_regional,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ID_W-1:0]   out_id,
  output logic              out_regional,
  output logic              req_miss,
  output logic [CNT_W-1:0]  ovf_count
);
  logic [DATA_W-1:0] pipe_word, lk_data;
  logic [ID_W-1:0]   id_next;
  logic              evb_full, lk_hit, req_fire;
  req_kind_e         kind;

  assign kind      = req_kind_e'(req_regional);
  assign req_ready = !out_valid || out_ready;
  assign req_fire  = req_valid && req_ready;

  tlp_pipeline #(.DATA_W(DATA_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .hit_word(hit_word),
    .lat(lat_cfg), .rd_word(pipe_word)
  );

  tlp_evbuf #(.DATA_W(DATA_W), .ID_W(ID_W), .SLOTS(EVB_SLOTS)) u_evb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(l1_accept), .wr_data(pipe_word), .wr_id(id_next), .full(evb_full),
    .lk_en(req_fire), .lk_consume(kind == REQ_SECOND), .lk_id(req_id),
    .lk_hit(lk_hit), .lk_data(lk_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_next   <= '0;
      ovf_count <= '0;
    end else if (l1_accept) begin
      if (evb_full) ovf_count <= ovf_count + 1'b1;
      else          id_next   <= id_next + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_id       <= '0;
      out_regional <= 1'b0;
      req_miss     <= 1'b0;
    end else begin
      req_miss <= req_fire && !lk_hit;
      if (req_fire && lk_hit) begin
        out_valid    <= 1'b1;
        out_data     <= lk_data;
        out_id       <= req_id;
        out_regional <= (kind == REQ_REGIONAL);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlp_checker.sv
module tlp_checker #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l1_accept,
  input logic              req_ready,
  input logic              req_miss,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [ID_W-1:0]   out_id,
  input logic              out_regional,
  input logic [CNT_W-1:0]  ovf_count
);
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_id) && $stable(out_regional));

  p_ready_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> req_ready);

  p_ovf_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_count == $past(ovf_count)) || (ovf_count == $past(ovf_count) + 1'b1));

  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> $past(l1_accept));

  p_miss_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_miss && !$past(out_valid) |-> !out_valid);
endmodule

bind trig_latency_pipe tlp_checker #(.DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_tlp_checker (
  .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept), .req_ready(req_ready),
  .req_miss(req_miss), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_id(out_id), .out_regional(out_regional),
  .ovf_count(ovf_count)
);

// File: tb/trig_latency_pipe_bench.sv
module trig_latency_pipe_bench;
  localparam int DW = 16, DEPTH = 64, SLOTS = 4, IW = 8, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bc_strobe = 0, l1_accept = 0, req_valid = 0, req_regional = 0, out_ready = 1;
  logic [DW-1:0] hit_word = '0;
  logic [5:0]    lat_cfg = 6'd10;
  logic [IW-1:0] req_id = '0;
  logic req_ready, out_valid, out_regional, req_miss;
  logic [DW-1:0] out_data;
  logic [IW-1:0] out_id;
  logic [CW-1:0] ovf_count;

  always #2.5 clk = ~clk;

  trig_latency_pipe #(.DATA_W(DW), .PIPE_DEPTH(DEPTH), .EVB_SLOTS(SLOTS), .ID_W(IW), .CNT_W(CW))
    u_trig_latency_pipe (.*);

  int n_chk = 0, n_fail = 0, bc_cnt = 0, ovf_exp = 0;
  int next_id = 0;
  logic [DW-1:0] exp_data [256];
  logic [DW+IW:0] sb_q [$];
  bit finished = 0;

  function automatic logic [DW-1:0] hval(int j);
    return DW'(j * 313) ^ 16'h5A5A;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n, bit strobe);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bc_strobe = strobe; l1_accept = 0; hit_word = hval(bc_cnt);
      @(posedge clk);
      if (strobe) bc_cnt++;
    end
    @(negedge clk);
    bc_strobe = 0;
  endtask

  // R2 R3 R7: first-level accept with the model's expectation
  task automatic l1(bit strobe, bit accept);
    @(negedge clk);
    bc_strobe = strobe; l1_accept = 1; hit_word = hval(bc_cnt);
    @(posedge clk);
    if (accept) begin
      exp_data[next_id] = hval(bc_cnt - int'(lat_cfg));
      next_id = (next_id + 1) % 256;
    end else ovf_exp++;
    if (strobe) bc_cnt++;
    @(negedge clk);
    l1_accept = 0; bc_strobe = 0;
    chk(ovf_count == CW'(ovf_exp), "R7 ovf_count", ovf_count, ovf_exp);
  endtask

  // driver: pushes expected results into the scoreboard
  task automatic req(int id, bit regional, bit hit);
    @(negedge clk);
    req_valid = 1; req_id = IW'(id); req_regional = regional;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (hit) sb_q.push_back({regional, IW'(id), exp_data[id]});
    @(negedge clk);
    req_valid = 0;
    chk(req_miss == !hit, hit ? "R4 R5 no miss on hit" : "R6 miss flag", req_miss, !hit);
    @(negedge clk);
    chk(req_miss == 1'b0, "R6 miss lasts one cycle", req_miss, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [DW+IW:0] got, want;
      got = {out_regional, out_id, out_data};
      if (sb_q.size() == 0) chk(0, "R6 unexpected result", got, 0);
      else begin
        want = sb_q.pop_front();
        chk(got == want, "R1 R2 R3 R4 R5 result", got, want);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(req_miss == 0, "R10 req_miss", req_miss, 0);
    chk(ovf_count == 0, "R10 ovf_count", ovf_count, 0);
    chk(req_ready == 1, "R10 req_ready", req_ready, 1);

    idle(70, 1);                         // R1 prefill
    l1(1, 1); req(0, 0, 1);              // R2 R3 R4 id 0
    lat_cfg = 6'd1;  l1(1, 1); req(1, 0, 1);
    lat_cfg = 6'd63; l1(0, 1); req(2, 0, 1);  // R2 no strobe in accept cycle
    idle(5, 0);                          // R1 no write without strobe
    lat_cfg = 6'd5;  l1(0, 1); req(3, 0, 1);
    l1(1, 1); req(4, 0, 1);
    req(4, 0, 0);                        // R4 consumed
    // R5 regional leaves the event in place
    l1(1, 1); req(5, 1, 1); req(5, 1, 1); req(5, 0, 1); req(5, 0, 0);
    req(200, 0, 0);                      // R6 never issued
    idle(4, 1);

    // R7 R8 fill, overflow and in-order release (ids 6..9)
    l1(1, 1); l1(1, 1); l1(0, 1); l1(1, 1);
    l1(1, 0); l1(1, 0);
    req(8, 0, 1); idle(3, 1);
    l1(1, 0);                            // R8 oldest still held
    req(6, 0, 1); idle(3, 1);
    l1(1, 1);                            // R8 one slot free, gets id 10
    l1(1, 0);
    req(7, 0, 1); req(9, 0, 1); req(10, 0, 1);
    idle(4, 1);

    // R9 back-pressure
    l1(1, 1); l1(1, 1);                  // ids 11, 12
    @(negedge clk); out_ready = 0;
    req(11, 0, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1, "R9 held valid", out_valid, 1);
      chk(out_id == 8'd11, "R9 held id", out_id, 11);
      chk(req_ready == 0, "R9 req_ready low", req_ready, 0);
    end
    out_ready = 1;
    req(12, 0, 1);
    idle(3, 1);

    // R3 wrap past 255
    for (int n = 0; n < 260; n++) begin
      l1(1, 1);
      req((next_id + 255) % 256, 0, 1);
    end
    idle(6, 1);
    chk(sb_q.size() == 0, "R6 all results seen", sb_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule